// File: doc/BRIEF.md
# PCI-X Target Read Request Router

This block sits at the target side of a conventional-PCI / PCI-X bridge. Each cycle that an address phase is accepted (`addr_vld`), it decodes the 4-bit bus command. The decode depends on whether the bus runs in conventional mode or in PCI-X mode. From that decode the block decides whether to claim the transaction and whether to acknowledge a 64-bit transfer. It then sends memory reads down one of two paths.

Reads that hit the internal register window go to an immediate-completion path. That path never widens to 64 bits and signals its completion a fixed number of clocks after acceptance. Every other memory read becomes a delayed request, or a split request in PCI-X mode. The block records it in one of a small number of request slots, together with an upstream prefetch byte count. That count comes from the command class and the 64-bit request, and it is cut short so that it stops at the next 4 KB page boundary.

When no slot is free, the block asks the initiator to retry in conventional mode and signals a disconnect in PCI-X mode. An address phase with bad parity is reported and never takes a slot. A slot is released when the upstream side reports that its completion has been fully delivered.

Top module: `pxt_read_router`

## Requirements
- R1: Claim decode. In conventional mode the block claims 0010, 0011, 0110, 0111, 1100, 1110 and 1111. In PCI-X mode it claims 0010, 0011, 0110, 0111, 1000, 1001, 1100, 1110 and 1111. Every other code is not claimed in the respective mode, including 0000, 0001, 0100 and 0101.
- R2: `ack64` equals `req64` for a claimed non-I/O transaction outside the register window. It is 0 for I/O codes (0010, 0011), for any transaction with `csr_hit` set, and for unclaimed codes.
- R3: A memory read with `csr_hit` set pulses `csr_rd`, writes no slot and raises no retry or disconnect. `csr_cpl` pulses exactly `CSR_LAT` clocks after `csr_rd` (default 4). `CSR_LAT` must not exceed 16.
- R4: A memory read outside the register window, with good parity and a free slot, pulses `q_wr`. It presents the latched address, command and parity bit, and uses the lowest-numbered free slot as `q_idx`.
- R5: `q_split` on a slot write equals the bus mode (1 = PCI-X, split completion; 0 = conventional, delayed completion).
- R6: The base prefetch length comes from the read class. A single-word read (0110) is 4 bytes. A read line (1110, conventional) is 32 bytes. A read multiple (1100, conventional) is 128 bytes. A block read (1000 or 1110, PCI-X) is 256 bytes. The line, multiple and block lengths double when `req64` is 1.
- R7: `q_len` is the smaller of the base length and 4096 minus `addr[11:0]`, so the prefetch never crosses a 4 KB page.
- R8: When a slot write is needed but all 4 slots are busy, no slot is written. The block pulses `retry` in conventional mode and `disconnect` in PCI-X mode.
- R9: Parity is even over `addr`, `cmd` and `addr_par` together. On a mismatch the block pulses `par_err` and writes no slot. Claim and `ack64` are unaffected.
- R10: `cpl_done` with `cpl_idx` frees that slot. It is available to the next allocation one cycle later.
- R11: All responses are registered. They appear the cycle after `addr_vld`, and every response pulse is 0 in any cycle that does not follow an accepted address phase. All outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_vld | input | 1 | Address phase accepted this cycle |
| cmd | input | 4 | Bus command code |
| addr | input | 64 | Transaction address |
| addr_par | input | 1 | Address-phase parity bit |
| req64 | input | 1 | Initiator requests 64-bit transfer |
| pcix_mode | input | 1 | 1 = PCI-X mode, 0 = conventional mode |
| csr_hit | input | 1 | Address falls in the internal register window |
| cpl_done | input | 1 | Completion for slot `cpl_idx` fully delivered |
| cpl_idx | input | 2 | Slot being released |
| resp_vld | output | 1 | Response fields below are valid this cycle |
| claim | output | 1 | Transaction claimed |
| ack64 | output | 1 | 64-bit acknowledge |
| retry | output | 1 | Slots full, conventional mode |
| disconnect | output | 1 | Slots full, PCI-X mode |
| par_err | output | 1 | Address parity mismatch |
| csr_rd | output | 1 | Register-window read sent to the immediate path |
| csr_cpl | output | 1 | Immediate completion due |
| q_wr | output | 1 | Slot write strobe |
| q_idx | output | 2 | Slot written |
| q_addr | output | 64 | Latched address |
| q_cmd | output | 4 | Latched command |
| q_par | output | 1 | Latched parity bit |
| q_len | output | 13 | Prefetch byte count |
| q_split | output | 1 | Slot uses split completion |

## Verification
On every cycle the embedded assertions check several properties. A register-window read never raises `ack64` or a slot write. A slot write never lets the prefetch run past a page end. Write, retry and disconnect are mutually exclusive. A parity error never allocates. An allocated slot becomes busy. The immediate path stays below its 16-clock bound. Other properties can only be shown by the bench's scenarios: the exact claim map in both modes, the base-length table, the lowest-free slot choice, the exact completion latency, and the reuse of a slot after its release.

// File: rtl/pxt_pkg.sv
// Shared types for the target read router.
// Assumes the standard 4-bit bus command encoding.
package pxt_pkg;
    typedef enum logic [2:0] {
        RD_NONE  = 3'd0,
        RD_DWORD = 3'd1,
        RD_LINE  = 3'd2,
        RD_MULT  = 3'd3,
        RD_BLOCK = 3'd4
    } rd_kind_e;
endpackage

// File: rtl/pxt_cmd_decode.sv
// Command decoder: turns the bus command and mode into a claim decision,
// an I/O flag and a read class. Purely combinational.
module pxt_cmd_decode
    import pxt_pkg::*;
(
    input  logic [3:0] cmd,
    input  logic       pcix_mode,
    output logic       claim,
    output logic       is_io,
    output rd_kind_e   rd_kind
);
    // Mode-dependent command map.
    always_comb begin
        claim   = 1'b0;
        is_io   = 1'b0;
        rd_kind = RD_NONE;
        case (cmd)
            4'b0010, 4'b0011: begin claim = 1'b1; is_io = 1'b1; end
            4'b0110:          begin claim = 1'b1; rd_kind = RD_DWORD; end
            4'b0111, 4'b1111: claim = 1'b1;
            4'b1000:          begin claim = pcix_mode; rd_kind = pcix_mode ? RD_BLOCK : RD_NONE; end
            4'b1001:          claim = pcix_mode;
            4'b1100:          begin claim = 1'b1; rd_kind = pcix_mode ? RD_NONE : RD_MULT; end
            4'b1110:          begin claim = 1'b1; rd_kind = pcix_mode ? RD_BLOCK : RD_LINE; end
            default:          claim = 1'b0;
        endcase
    end
endmodule

// File: rtl/pxt_prefetch.sv
// Prefetch sizer: base length from read class and 64-bit request, clipped
// to the distance to the next page boundary. Assumes PAGE_B is a power of two.
module pxt_prefetch
    import pxt_pkg::*;
#(
    parameter int LINE_B  = 32,
    parameter int MULT_B  = 128,
    parameter int BLOCK_B = 256,
    parameter int PAGE_B  = 4096,
    localparam int OFF_W  = $clog2(PAGE_B),
    localparam int LEN_W  = OFF_W + 1
) (
    input  rd_kind_e           rd_kind,
    input  logic               req64,
    input  logic [OFF_W-1:0]   page_off,
    output logic [LEN_W-1:0]   len
);
    logic [LEN_W-1:0] base;
    logic [LEN_W-1:0] room;

    // Base length table.
    always_comb begin
        case (rd_kind)
            RD_DWORD: base = LEN_W'(4);
            RD_LINE:  base = req64 ? LEN_W'(2*LINE_B)  : LEN_W'(LINE_B);
            RD_MULT:  base = req64 ? LEN_W'(2*MULT_B)  : LEN_W'(MULT_B);
            RD_BLOCK: base = req64 ? LEN_W'(2*BLOCK_B) : LEN_W'(BLOCK_B);
            default:  base = '0;
        endcase
    end

    // Clip at the page boundary.
    always_comb begin
        room = LEN_W'(PAGE_B) - {1'b0, page_off};
        len  = (base < room) ? base : room;
    end
endmodule

// File: rtl/pxt_dtq.sv
// Request slot tracker: a busy bit per slot, lowest-free allocation and
// release on completion. Assumes the caller only allocates when not full.
module pxt_dtq #(
    parameter int DEPTH = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_go,
    input  logic             free_req,
    input  logic [IDX_W-1:0] free_idx,
    output logic             full,
    output logic [IDX_W-1:0] alloc_idx
);
    logic [DEPTH-1:0] vld;

    // Lowest free slot search.
    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH-1; i >= 0; i--)
            if (!vld[i]) alloc_idx = IDX_W'(i);
        full = &vld;
    end

    // Per-slot busy bit: set on allocation, cleared on release.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld[g] <= 1'b0;
            else if (alloc_go && alloc_idx == IDX_W'(g))
                vld[g] <= 1'b1;
            else if (free_req && free_idx == IDX_W'(g))
                vld[g] <= 1'b0;
        end
    end

    AST_ALLOC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_go |=> vld[$past(alloc_idx)]); // R4
    AST_NO_ALLOC_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_go |-> $countones(vld) < DEPTH); // R8
endmodule

// File: rtl/pxt_csr_timer.sv
// Immediate-path timer: after a start pulse, raises done exactly LAT clocks
// later. Assumes no new start while a previous one is pending.
module pxt_csr_timer #(
    parameter int LAT   = 4,
    parameter int BOUND = 16,
    localparam int CW   = $clog2(LAT + 1),
    localparam int EW   = $clog2(BOUND + 1) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt;
    logic [EW-1:0] elapsed;

    // Countdown to the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= CW'(LAT);
            end else if (busy) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Independent cycle count used only by the bound check.
    always_ff @(posedge clk) begin
        if (!rst_n)                       elapsed <= '0;
        else if (start)                   elapsed <= '0;
        else if (busy && elapsed < EW'(BOUND)) elapsed <= elapsed + 1'b1;
    end

    AST_CSR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> elapsed < EW'(BOUND)); // R3
    AST_CSR_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy); // R3
endmodule

// File: rtl/pxt_read_router.sv
// Target read router top: registers the claim/ack64 response, steers
// register-window reads to the immediate path and other memory reads into
// request slots with a clipped prefetch length. Assumes one address phase
// at a time and no new register-window read before the previous completes.
module pxt_read_router
    import pxt_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int CSR_LAT = 4,
    parameter int LINE_B  = 32,
    parameter int MULT_B  = 128,
    parameter int BLOCK_B = 256,
    localparam int PAGE_B = 4096,
    localparam int OFF_W  = $clog2(PAGE_B),
    localparam int LEN_W  = OFF_W + 1,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_vld,
    input  logic [3:0]       cmd,
    input  logic [63:0]      addr,
    input  logic             addr_par,
    input  logic             req64,
    input  logic             pcix_mode,
    input  logic             csr_hit,
    input  logic             cpl_done,
    input  logic [IDX_W-1:0] cpl_idx,
    output logic             resp_vld,
    output logic             claim,
    output logic             ack64,
    output logic             retry,
    output logic             disconnect,
    output logic             par_err,
    output logic             csr_rd,
    output logic             csr_cpl,
    output logic             q_wr,
    output logic [IDX_W-1:0] q_idx,
    output logic [63:0]      q_addr,
    output logic [3:0]       q_cmd,
    output logic             q_par,
    output logic [LEN_W-1:0] q_len,
    output logic             q_split
);
    logic             dec_claim, dec_io;
    rd_kind_e         dec_kind;
    logic [LEN_W-1:0] pf_len;
    logic             perr, is_rd, need_slot, alloc_go, stall, csr_go;
    logic             q_full, csr_busy;
    logic [IDX_W-1:0] alloc_idx;

    pxt_cmd_decode u_dec (
        .cmd(cmd), .pcix_mode(pcix_mode),
        .claim(dec_claim), .is_io(dec_io), .rd_kind(dec_kind)
    );

    pxt_prefetch #(.LINE_B(LINE_B), .MULT_B(MULT_B), .BLOCK_B(BLOCK_B), .PAGE_B(PAGE_B)) u_pf (
        .rd_kind(dec_kind), .req64(req64), .page_off(addr[OFF_W-1:0]), .len(pf_len)
    );

    pxt_dtq #(.DEPTH(DEPTH)) u_dtq (
        .clk(clk), .rst_n(rst_n), .alloc_go(alloc_go),
        .free_req(cpl_done), .free_idx(cpl_idx),
        .full(q_full), .alloc_idx(alloc_idx)
    );

    pxt_csr_timer #(.LAT(CSR_LAT)) u_csr (
        .clk(clk), .rst_n(rst_n), .start(csr_go), .busy(csr_busy), .done(csr_cpl)
    );

    // Routing decision for the current address phase.
    always_comb begin
        perr      = ^{addr, cmd, addr_par};
        is_rd     = dec_kind != RD_NONE;
        csr_go    = addr_vld && is_rd && csr_hit;
        need_slot = addr_vld && is_rd && !csr_hit && !perr;
        alloc_go  = need_slot && !q_full;
        stall     = need_slot && q_full;
    end

    // Registered response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_vld   <= 1'b0;
            claim      <= 1'b0;
            ack64      <= 1'b0;
            retry      <= 1'b0;
            disconnect <= 1'b0;
            par_err    <= 1'b0;
            csr_rd     <= 1'b0;
            q_wr       <= 1'b0;
        end else begin
            resp_vld   <= addr_vld;
            claim      <= addr_vld && dec_claim;
            ack64      <= addr_vld && dec_claim && !dec_io && !csr_hit && req64;
            retry      <= stall && !pcix_mode;
            disconnect <= stall && pcix_mode;
            par_err    <= addr_vld && perr;
            csr_rd     <= csr_go;
            q_wr       <= alloc_go;
        end
    end

    // Slot payload, loaded on allocation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_idx   <= '0;
            q_addr  <= '0;
            q_cmd   <= '0;
            q_par   <= 1'b0;
            q_len   <= '0;
            q_split <= 1'b0;
        end else if (alloc_go) begin
            q_idx   <= alloc_idx;
            q_addr  <= addr;
            q_cmd   <= cmd;
            q_par   <= addr_par;
            q_len   <= pf_len;
            q_split <= pcix_mode;
        end
    end

    AST_CSR_NO_ACK64: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd |-> !ack64); // R2
    AST_CSR_NO_QWR: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd |-> !q_wr && !retry && !disconnect); // R3
    AST_PAGE_CLIP: assert property (@(posedge clk) disable iff (!rst_n)
        q_wr |-> (14'(q_addr[OFF_W-1:0]) + 14'(q_len)) <= 14'(PAGE_B)); // R7
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_wr, retry, disconnect})); // R8
    AST_PERR_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |-> !q_wr); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_vld |=> !resp_vld && !claim && !q_wr && !csr_rd); // R11
    AST_CSR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        csr_rd |-> csr_busy); // R3
endmodule

// File: tb/tb_pxt_read_router.sv
module tb_pxt_read_router;
    localparam int CSR_LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_vld = 1'b0;
    logic [3:0]  cmd = '0;
    logic [63:0] addr = '0;
    logic        addr_par = 1'b0;
    logic        req64 = 1'b0;
    logic        pcix_mode = 1'b0;
    logic        csr_hit = 1'b0;
    logic        cpl_done = 1'b0;
    logic [1:0]  cpl_idx = '0;
    logic        resp_vld, claim, ack64, retry, disconnect, par_err, csr_rd, csr_cpl;
    logic        q_wr, q_par, q_split;
    logic [1:0]  q_idx;
    logic [63:0] q_addr;
    logic [3:0]  q_cmd;
    logic [12:0] q_len;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pxt_read_router #(.CSR_LAT(CSR_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .cmd(cmd), .addr(addr),
        .addr_par(addr_par), .req64(req64), .pcix_mode(pcix_mode), .csr_hit(csr_hit),
        .cpl_done(cpl_done), .cpl_idx(cpl_idx), .resp_vld(resp_vld), .claim(claim),
        .ack64(ack64), .retry(retry), .disconnect(disconnect), .par_err(par_err),
        .csr_rd(csr_rd), .csr_cpl(csr_cpl), .q_wr(q_wr), .q_idx(q_idx), .q_addr(q_addr),
        .q_cmd(q_cmd), .q_par(q_par), .q_len(q_len), .q_split(q_split)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_claim(input logic [3:0] c, input logic m);
        case (c)
            4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return 1'b1;
            4'b1000, 4'b1001: return m;
            default: return 1'b0;
        endcase
    endfunction

    // Present one address phase; outputs are valid at return.
    task automatic issue(input logic [3:0] c, input logic [63:0] a, input logic r64,
                         input logic m, input logic hit, input logic bad);
        @(negedge clk);
        cmd = c; addr = a; req64 = r64; pcix_mode = m; csr_hit = hit;
        addr_par = (^{a, c}) ^ bad;
        addr_vld = 1'b1;
        @(negedge clk);
        addr_vld = 1'b0;
    endtask

    task automatic release_slot(input logic [1:0] i);
        @(negedge clk);
        cpl_done = 1'b1; cpl_idx = i;
        @(negedge clk);
        cpl_done = 1'b0;
    endtask

    task automatic t_reset;
        check("R11 reset resp_vld", resp_vld, 0);
        check("R11 reset claim", claim, 0);
        check("R11 reset q_wr", q_wr, 0);
        check("R11 reset csr_cpl", csr_cpl, 0);
    endtask

    // R1 with bad parity so nothing allocates; R9 no write.
    task automatic t_claim_map;
        for (int m = 0; m < 2; m++)
            for (int c = 0; c < 16; c++) begin
                issue(4'(c), 64'h40, 1'b0, 1'(m), 1'b0, 1'b1);
                check($sformatf("R1 claim cmd=%0h mode=%0d", c, m), claim, exp_claim(4'(c), 1'(m)));
                check("R9 par_err", par_err, 1);
                check("R9 no q_wr", q_wr, 0);
            end
    endtask

    task automatic t_ack64;
        issue(4'b0111, 64'h100, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 mem write req64", ack64, 1);
        issue(4'b0111, 64'h100, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R2 mem write no req64", ack64, 0);
        issue(4'b0011, 64'h100, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R2 io write", ack64, 0);
        issue(4'b1111, 64'h100, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R2 csr write", ack64, 0);
        issue(4'b0001, 64'h100, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R2 unclaimed", ack64, 0);
        @(negedge clk);
        check("R11 quiet after phase", resp_vld, 0);
    endtask

    task automatic t_fill;
        issue(4'b1110, 64'h1_0000_0F80, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R4 q_wr", q_wr, 1);
        check("R4 idx0", q_idx, 0);
        check("R4 addr", q_addr, 64'h1_0000_0F80);
        check("R4 cmd", q_cmd, 4'b1110);
        check("R4 par", q_par, ^{64'h1_0000_0F80, 4'b1110});
        check("R5 split", q_split, 1);
        check("R7 clipped block", q_len, 128);
        check("R2 read ack64", ack64, 1);
        issue(4'b1100, 64'h2000, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R4 idx1", q_idx, 1);
        check("R5 delayed", q_split, 0);
        check("R6 multiple", q_len, 128);
        issue(4'b1110, 64'h10, 1'b1, 1'b0, 1'b0, 1'b0);
        check("R4 idx2", q_idx, 2);
        check("R6 line x64", q_len, 64);
        issue(4'b0110, 64'hFFC, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R4 idx3", q_idx, 3);
        check("R6 dword", q_len, 4);
    endtask

    task automatic t_full;
        issue(4'b0110, 64'h500, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 retry", retry, 1);
        check("R8 no disconnect", disconnect, 0);
        check("R8 no q_wr", q_wr, 0);
        issue(4'b1000, 64'h500, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R8 disconnect", disconnect, 1);
        check("R8 no retry", retry, 0);
        check("R8 claim kept", claim, 1);
    endtask

    task automatic t_csr;
        int seen;
        issue(4'b0110, 64'h8000_0000, 1'b1, 1'b1, 1'b1, 1'b0);
        check("R3 csr_rd", csr_rd, 1);
        check("R3 no q_wr", q_wr, 0);
        check("R3 no disconnect", disconnect, 0);
        check("R2 csr read ack64", ack64, 0);
        seen = 0;
        for (int n = 1; n <= CSR_LAT + 2; n++) begin
            @(negedge clk);
            if (csr_cpl && seen == 0) seen = n;
        end
        check("R3 latency", 64'(seen), 64'(CSR_LAT));
    endtask

    task automatic t_release;
        release_slot(2'd2);
        issue(4'b1000, 64'h3000, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R10 reuse q_wr", q_wr, 1);
        check("R10 reuse idx2", q_idx, 2);
        check("R6 block x64 at page start", q_len, 512);
        issue(4'b1000, 64'h3000, 1'b0, 1'b1, 1'b0, 1'b0);
        check("R10 full again", disconnect, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_claim_map();
        t_ack64();
        t_fill();
        t_full();
        t_csr();
        t_release();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule